// File: doc/BRIEF.md
# Two-Processor Interrupt Controller with Cross-Processor Doorbell

This block keeps the interrupt state for two processors and drives one level-sensitive interrupt line to each. Every processor owns a bank made of three registers: a one-bit global enable, a 32-bit per-source enable mask and a 32-bit pending-flag register. Hardware sources raise single-cycle request pulses on a 32-bit vector per processor. A pulse latches into the pending flags only when the processor's global enable is on and its enable-mask bit for that source is set. Software acknowledges a pending source by writing a one to its flag bit.

A small doorbell register per processor lets one processor interrupt the other. Each side stores a few handshake bits. When one side writes its doorbell with the "ring" bit set, the other side receives a request on source 16, provided the other side has armed its own doorbell. That request then passes through the receiving bank's normal enable checks.

Software reaches all registers through one write/read port. A processor-select input picks the bank. Reads are combinational.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, every global enable, enable mask, pending-flag and doorbell register of both banks reads zero, and both interrupt outputs are low.
- R2: The global enable register sits at offset 0x208 and stores only write-data bit 0; it reads back with bits 31..1 zero. While it is zero, no request of any kind sets a pending bit in that bank.
- R3: A request pulse on source n (bit n of the request vector) sets pending bit n at the next clock edge only if enable-mask bit n (offset 0x210) is one and the global enable is one; otherwise the pulse is lost.
- R4: A write to the pending-flag register (offset 0x214) clears each pending bit whose write-data bit is one and leaves the others unchanged.
- R5: When a request and an acknowledge hit the same pending bit in the same cycle, the bit ends up set.
- R6: A processor's interrupt output is high exactly when its global enable is one and at least one bit is set in both its pending flags and its enable mask. Clearing the global enable drops the output without changing the pending flags.
- R7: The doorbell register (offset 0x180) stores write-data bits 8..11 and 14 (mask 0x4F00) and reads back zero in all other bits.
- R8: A doorbell write with bit 13 set, while the other processor's doorbell bit 14 is one, requests source 16 on the other processor. That request is subject to R2 and R3. It never requests anything on the writing processor.
- R9: A doorbell write with bit 13 clear, or with the other processor's bit 14 clear, requests nothing.
- R10: A register write changes only the bank chosen by the processor-select input (0 or 1).
- R11: Writes to offsets other than the four listed change nothing, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_cpu | input | 1 | Bank select: 0 or 1 |
| bus_addr | input | 12 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected bank and offset |
| evt_req_0 | input | 32 | Request pulses for processor 0, one bit per source |
| evt_req_1 | input | 32 | Request pulses for processor 1, one bit per source |
| irq_0 | output | 1 | Interrupt level to processor 0 |
| irq_1 | output | 1 | Interrupt level to processor 1 |

## Verification
The bench sweeps every source of both banks across all four combinations of global enable and mask bit, using a mask that is the source's own bit alone or every bit except it. A controller that ignored either gate, or set a neighbouring flag, would show a wrong pending word. It drives a request and an acknowledge of the same bit in the same cycle, which catches a design that lets the clear win. It walks all sixteen combinations of ring bit, peer arming and peer enables in both directions. A doorbell that ignored the arming bit, fired on the writer, or skipped the receiver's enables would leave source 16 wrong on one side. Stray writes and a global-enable drop with flags still pending catch loose address decoding and an ungated interrupt line.

// File: rtl/dual_irq_pkg.sv
package dual_irq_pkg;

  localparam int NUM_SRC  = 32;
  localparam int DATA_W   = 32;
  localparam int SYNC_W   = 16;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // register offsets decoded by software
  localparam logic [11:0] OFS_DOORBELL = 12'h180;
  localparam logic [11:0] OFS_GLOBAL   = 12'h208;
  localparam logic [11:0] OFS_MASK     = 12'h210;
  localparam logic [11:0] OFS_PENDING  = 12'h214;

  // doorbell fields
  localparam logic [SYNC_W-1:0] DB_KEEP = 16'h4F00;
  localparam int DB_RING_BIT = 13;
  localparam int DB_ARM_BIT  = 14;

  // source numbering
  typedef enum int {
    SRC_VBLANK = 0, SRC_HBLANK = 1, SRC_VMATCH = 2,
    SRC_TMR0 = 3, SRC_TMR1 = 4, SRC_TMR2 = 5, SRC_TMR3 = 6,
    SRC_CLOCK = 7, SRC_DMA0 = 8, SRC_DMA1 = 9, SRC_DMA2 = 10, SRC_DMA3 = 11,
    SRC_KEYS = 12, SRC_SLOT = 13,
    SRC_DOORBELL = 16, SRC_MBOX_EMPTY = 17, SRC_MBOX_FULL = 18,
    SRC_CARD_DONE = 19, SRC_CARD_REQ = 20, SRC_GEOM_FIFO = 21,
    SRC_HINGE = 22, SRC_SERIAL = 23, SRC_RADIO = 24
  } irq_src_e;

  // requests that survive both gates
  function automatic src_vec_t latch_mask(src_vec_t req, src_vec_t en, logic gen);
    return req & en & {NUM_SRC{gen}};
  endfunction

  // set wins over clear
  function automatic src_vec_t next_flags(src_vec_t cur, src_vec_t clr, src_vec_t set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic irq_level(src_vec_t fl, src_vec_t en, logic gen);
    return gen & (|(fl & en));
  endfunction

  function automatic src_vec_t onehot_src(int idx);
    src_vec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import dual_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_global,
  output logic              hit_mask,
  output logic              hit_pending,
  output logic              hit_doorbell
);
  localparam logic [ADDR_W-1:0] A_GLOBAL   = ADDR_W'(OFS_GLOBAL);
  localparam logic [ADDR_W-1:0] A_MASK     = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_PENDING  = ADDR_W'(OFS_PENDING);
  localparam logic [ADDR_W-1:0] A_DOORBELL = ADDR_W'(OFS_DOORBELL);

  assign hit_global   = (addr == A_GLOBAL);
  assign hit_mask     = (addr == A_MASK);
  assign hit_pending  = (addr == A_PENDING);
  assign hit_doorbell = (addr == A_DOORBELL);
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import dual_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     gen_wr,
  input  logic     gen_d,
  input  logic     mask_wr,
  input  src_vec_t mask_d,
  input  logic     ack_wr,
  input  src_vec_t ack_d,
  input  src_vec_t req,
  output logic     gen_q,
  output src_vec_t mask_q,
  output src_vec_t flags_q,
  output logic     irq
);
  // named internal events
  src_vec_t set_vec;
  src_vec_t clr_vec;

  assign set_vec = latch_mask(req, mask_q, gen_q);
  assign clr_vec = ack_wr ? ack_d : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q   <= 1'b0;
      mask_q  <= '0;
      flags_q <= '0;
    end else begin
      if (gen_wr)  gen_q  <= gen_d;
      if (mask_wr) mask_q <= mask_d;
      flags_q <= next_flags(flags_q, clr_vec, set_vec);
    end
  end

  assign irq = irq_level(flags_q, mask_q, gen_q);

  AST_OFF_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q |=> ((flags_q & ~$past(flags_q)) == '0)); // R2
  AST_MASK_GATES_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((flags_q & ~$past(flags_q) & ~$past(mask_q)) == '0)); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> ((flags_q & $past(clr_vec & ~set_vec)) == '0)); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec))); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q |-> !irq); // R6
endmodule

// File: rtl/ipc_doorbell.sv
module ipc_doorbell
  import dual_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [SYNC_W-1:0] wdata,
  output logic [SYNC_W-1:0] db_q,
  output logic              ring
);
  always_ff @(posedge clk) begin
    if (!rst_n) db_q <= '0;
    else if (wr) db_q <= wdata & DB_KEEP;
  end

  assign ring = wr & wdata[DB_RING_BIT];

  AST_DB_KEPT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |-> ((db_q & ~DB_KEEP) == '0)); // R7
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import dual_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_cpu,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] evt_req_0,
  input  logic [NUM_SRC-1:0] evt_req_1,
  output logic              irq_0,
  output logic              irq_1
);
  localparam int NCPU = 2;

  logic hit_global, hit_mask, hit_pending, hit_doorbell;

  logic [NCPU-1:0]              gen_q;
  logic [NCPU-1:0][NUM_SRC-1:0] mask_q;
  logic [NCPU-1:0][NUM_SRC-1:0] flags_q;
  logic [NCPU-1:0][NUM_SRC-1:0] evt;
  logic [NCPU-1:0][NUM_SRC-1:0] req;
  logic [NCPU-1:0][SYNC_W-1:0]  db_q;
  logic [NCPU-1:0]              ring;
  logic [NCPU-1:0]              ipc_to;
  logic [NCPU-1:0]              irq_v;
  logic [NCPU-1:0]              sel;

  assign evt[0] = evt_req_0;
  assign evt[1] = evt_req_1;

  irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .hit_global(hit_global), .hit_mask(hit_mask),
    .hit_pending(hit_pending), .hit_doorbell(hit_doorbell)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign sel[c]    = bus_wr && (bus_cpu == 1'(c));
    // peer rang while this side is armed
    assign ipc_to[c] = ring[NCPU-1-c] & db_q[c][DB_ARM_BIT];
    assign req[c]    = evt[c] | (ipc_to[c] ? onehot_src(SRC_DOORBELL) : '0);

    irq_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .gen_wr(sel[c] & hit_global), .gen_d(bus_wdata[0]),
      .mask_wr(sel[c] & hit_mask), .mask_d(bus_wdata[NUM_SRC-1:0]),
      .ack_wr(sel[c] & hit_pending), .ack_d(bus_wdata[NUM_SRC-1:0]),
      .req(req[c]),
      .gen_q(gen_q[c]), .mask_q(mask_q[c]), .flags_q(flags_q[c]),
      .irq(irq_v[c])
    );

    ipc_doorbell u_db (
      .clk(clk), .rst_n(rst_n),
      .wr(sel[c] & hit_doorbell), .wdata(bus_wdata[SYNC_W-1:0]),
      .db_q(db_q[c]), .ring(ring[c])
    );

    AST_IPC_REACHES_PEER: assert property (@(posedge clk) disable iff (!rst_n)
      (ipc_to[c] && gen_q[c] && mask_q[c][SRC_DOORBELL]) |=> flags_q[c][SRC_DOORBELL]); // R8
    AST_IPC_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      (ring[c] && !ipc_to[c] && !evt[c][SRC_DOORBELL] && !flags_q[c][SRC_DOORBELL])
        |=> !flags_q[c][SRC_DOORBELL]); // R8
  end

  assign irq_0 = irq_v[0];
  assign irq_1 = irq_v[1];

  always_comb begin
    bus_rdata = '0;
    if (hit_global)        bus_rdata = DATA_W'(gen_q[bus_cpu]);
    else if (hit_mask)     bus_rdata = DATA_W'(mask_q[bus_cpu]);
    else if (hit_pending)  bus_rdata = DATA_W'(flags_q[bus_cpu]);
    else if (hit_doorbell) bus_rdata = DATA_W'(db_q[bus_cpu]);
  end

  AST_ONE_BANK_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R10
endmodule

// File: tb/sim_dual_irq_ctrl.sv
`timescale 1ns/100ps
module sim_dual_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_cpu = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] evt_req_0 = '0;
  logic [31:0] evt_req_1 = '0;
  logic        irq_0, irq_1;

  int checks = 0;
  int fails = 0;

  // bench model
  logic        m_gen [2];
  logic [31:0] m_mask [2];
  logic [31:0] m_fl [2];
  logic [15:0] m_db [2];

  always #5 clk = ~clk;

  dual_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_cpu(bus_cpu),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_req_0(evt_req_0), .evt_req_1(evt_req_1), .irq_0(irq_0), .irq_1(irq_1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic rd(input int c, input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_cpu = c[0];
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  function automatic logic exp_irq(int c);
    return m_gen[c] & (|(m_fl[c] & m_mask[c]));
  endfunction

  task automatic check_all(input string tag);
    logic [31:0] v;
    @(negedge clk);
    #1;
    chk({tag, " R6 irq_0"}, {31'b0, irq_0}, {31'b0, exp_irq(0)});
    chk({tag, " R6 irq_1"}, {31'b0, irq_1}, {31'b0, exp_irq(1)});
    for (int c = 0; c < 2; c++) begin
      rd(c, 12'h208, v); chk({tag, " R2 global"}, v, {31'b0, m_gen[c]});
      rd(c, 12'h210, v); chk({tag, " R10 mask"}, v, m_mask[c]);
      rd(c, 12'h214, v); chk({tag, " R3 pending"}, v, m_fl[c]);
      rd(c, 12'h180, v); chk({tag, " R7 doorbell"}, v, {16'b0, m_db[c]});
      rd(c, 12'h20C, v); chk({tag, " R11 unmapped"}, v, 32'h0);
    end
  endtask

  // one clock of stimulus, model advanced from pre-edge state
  task automatic step(input logic wr, input int c, input logic [11:0] a,
                      input logic [31:0] d, input logic [31:0] r0, input logic [31:0] r1);
    logic [31:0] req [2];
    logic [31:0] clr [2];
    @(negedge clk);
    bus_wr = wr; bus_cpu = c[0]; bus_addr = a; bus_wdata = d;
    evt_req_0 = r0; evt_req_1 = r1;
    req[0] = r0; req[1] = r1;
    clr[0] = '0; clr[1] = '0;
    if (wr && a == 12'h180 && d[13] && m_db[1-c][14]) req[1-c] = req[1-c] | 32'h0001_0000;
    if (wr && a == 12'h214) clr[c] = d;
    for (int k = 0; k < 2; k++)
      m_fl[k] = (m_fl[k] & ~clr[k]) | (req[k] & m_mask[k] & {32{m_gen[k]}});
    if (wr) begin
      case (a)
        12'h208: m_gen[c] = d[0];
        12'h210: m_mask[c] = d;
        12'h180: m_db[c] = d[15:0] & 16'h4F00;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; evt_req_0 = '0; evt_req_1 = '0;
  endtask

  task automatic clear_all();
    for (int c = 0; c < 2; c++) begin
      step(1, c, 12'h214, 32'hFFFF_FFFF, 0, 0);
      step(1, c, 12'h208, 32'h0, 0, 0);
      step(1, c, 12'h210, 32'h0, 0, 0);
      step(1, c, 12'h180, 32'h0, 0, 0);
    end
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_gen[k] = 0; m_mask[k] = 0; m_fl[k] = 0; m_db[k] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check_all("R1 reset");

    // R2 R3 sweep: every source, every gate combination
    for (int c = 0; c < 2; c++)
      for (int n = 0; n < 32; n++)
        for (int m = 0; m < 4; m++) begin
          logic [31:0] bit_n;
          bit_n = 32'h1 << n;
          step(1, c, 12'h208, {31'b0, m[0]} | 32'hFFFF_FFFE, 0, 0);
          step(1, c, 12'h210, m[1] ? bit_n : ~bit_n, 0, 0);
          step(0, c, 12'h000, 0, c == 0 ? bit_n : 0, c == 1 ? bit_n : 0);
          check_all("R3 sweep");
          step(1, c, 12'h214, 32'hFFFF_FFFF, 0, 0);
          check_all("R4 ack all");
        end
    clear_all();

    // R4 partial acknowledge
    step(1, 0, 12'h208, 1, 0, 0);
    step(1, 0, 12'h210, 32'hFFFF_FFFF, 0, 0);
    step(0, 0, 12'h000, 0, 32'hA5A5_1234, 32'hFFFF_FFFF);
    step(1, 0, 12'h214, 32'h0000_1230, 0, 0);
    check_all("R4 partial ack");

    // R5 request and ack on the same bit in one cycle
    step(1, 0, 12'h214, 32'h0000_0008, 32'h0000_0008, 0);
    check_all("R5 set beats clear");

    // R6 dropping global enable keeps flags, lowers line
    step(1, 0, 12'h208, 0, 0, 0);
    check_all("R6 gate off");
    step(1, 0, 12'h208, 1, 0, 0);
    check_all("R6 gate on");
    clear_all();

    // R7 doorbell stored bits
    for (int b = 0; b < 16; b++) begin
      step(1, b % 2, 12'h180, 32'hFFFF_0000 | (32'h1 << b), 0, 0);
      check_all("R7 doorbell bit");
    end
    clear_all();

    // R8 R9 doorbell combinations in both directions
    for (int w = 0; w < 2; w++)
      for (int m = 0; m < 16; m++) begin
        int p;
        p = 1 - w;
        step(1, p, 12'h180, m[1] ? 32'h4000 : 32'h0F00, 0, 0);
        step(1, p, 12'h208, {31'b0, m[2]}, 0, 0);
        step(1, p, 12'h210, m[3] ? 32'h0001_0000 : 32'hFFFE_FFFF, 0, 0);
        step(1, w, 12'h208, 1, 0, 0);
        step(1, w, 12'h210, 32'hFFFF_FFFF, 0, 0);
        step(1, w, 12'h180, m[0] ? 32'h6F00 : 32'h4F00, 0, 0);
        if (m[0] && m[1]) check_all("R8 doorbell rings");
        else check_all("R9 doorbell silent");
        clear_all();
      end

    // R11 stray writes
    step(1, 0, 12'h20C, 32'hFFFF_FFFF, 0, 0);
    step(1, 1, 12'h000, 32'hFFFF_FFFF, 0, 0);
    step(1, 1, 12'h181, 32'hFFFF_FFFF, 0, 0);
    check_all("R11 stray write");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule